// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Output Enable Controller

This block derives a set of gated clock outputs from one fast internal clock. A two-bit phase divider produces a CPU-rate waveform at half the internal clock rate and a PCI-rate waveform at half the CPU rate. Each output has its own flop, so every output edge lines up with an internal clock edge. The block drives a group of CPU clock outputs, a group of stoppable PCI clock outputs and one free-running PCI clock. The reference and memory clock groups are not generated here. For those groups the block only reports a run flag and per-output drive flags.

Three active-low controls act on the clocks, and they act only while the mode input is low:
- A CPU stop parks the CPU group low.
- A PCI stop parks the stoppable PCI group low.
- An asynchronous power-down parks every generated clock low and clears the run flags.

Every gating decision is taken at the edge where the affected waveform is about to fall. As a result, the last high phase before a stop and the first high phase after a restart always have full width. After a CPU stop ends, the CPU group waits a minimum number of CPU cycles before it runs again. An output-enable pin and a per-output enable word together set the tristate (drive) flag of every output.

Top module: `clkstop_ctrl`

## Requirements
- R1: During reset all clock outputs are low and the divider phase is zero. At the first internal edge after reset the CPU outputs go high and the PCI outputs stay low. At the second edge the CPU outputs go low and the PCI outputs go high.
- R2: While running, each CPU output has a period of 2 internal clocks. Every PCI output, gated or free-running, has a period of 4 internal clocks, which is half the CPU rate.
- R3: With mode low and the CPU stop input low, the CPU outputs are held low. The PCI outputs, the free-running PCI output and the memory run flag keep running.
- R4: After the CPU stop input returns high, the CPU outputs stay low for at least 3 CPU cycles (6 internal clocks). They run again within 12 internal clocks.
- R5: With mode low and the PCI stop input low, the gated PCI outputs are held low. The CPU outputs and the free-running PCI output keep running.
- R6: Every high pulse has full width: 1 internal clock on a CPU output and 2 internal clocks on a PCI output. A pulse is never cut short by a stop or a power-down.
- R7: With mode high, the CPU stop, PCI stop and power-down inputs have no effect on any output.
- R8: With mode low and the power-down input low, after its two-flop synchroniser every clock output goes low at the end of its current cycle. The reference and memory run flags go low. The enable-driven tristate flags keep their values.
- R9: With the output-enable input low, every drive flag (CPU, PCI, free PCI, reference, memory) is 0, whatever the enable word holds.
- R10: With the output-enable input high, each drive flag equals its own enable bit, with no delay.
- R11: When power-down is released, all clock groups resume at the normal rates. The reference and memory run flags return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Low enables the stop and power-down controls |
| oe_i | input | 1 | Low forces all drive flags off |
| cpu_stop_n_i | input | 1 | Active-low synchronous CPU clock stop |
| pci_stop_n_i | input | 1 | Active-low synchronous PCI clock stop |
| pwr_dn_n_i | input | 1 | Active-low asynchronous power-down |
| cpu_en_i | input | NCPU | Per-output CPU enable bits |
| pci_en_i | input | NPCI | Per-output gated PCI enable bits |
| pcif_en_i | input | 1 | Free-running PCI enable bit |
| ref_en_i | input | 1 | Reference output enable bit |
| mem_en_i | input | NMEM | Memory clock enable bits |
| cpu_clk_o | output | NCPU | CPU clock outputs |
| pci_clk_o | output | NPCI | Gated PCI clock outputs |
| pcif_clk_o | output | 1 | Free-running PCI clock |
| cpu_oe_o | output | NCPU | CPU drive flags |
| pci_oe_o | output | NPCI | Gated PCI drive flags |
| pcif_oe_o | output | 1 | Free PCI drive flag |
| ref_oe_o | output | 1 | Reference drive flag |
| mem_oe_o | output | NMEM | Memory clock drive flags |
| ref_run_o | output | 1 | Reference group running |
| mem_run_o | output | 1 | Memory group running |

## Verification
The drive flags are combinational, so the sweep over every enable word and output-enable value checks them one time step after each new input, in the same cycle. A clock output changes one internal clock after the decision that produces it. The bench therefore samples on the falling edge and does not check exact edge positions. After each control change it waits a settling window that covers the input flop or the two-flop synchroniser plus up to one full PCI cycle to reach a boundary. It then counts rising edges over a fixed 40-sample window and checks pulse widths throughout the run. The restart latency is measured as the count of falling-edge samples from release of the CPU stop to the first high CPU sample, which must fall between 6 and 12.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int PH_W = 2;
  localparam logic [1:0] LAT_DONE = 2'd3;

  function automatic logic [PH_W-1:0] ph_step(input logic [PH_W-1:0] p);
    return p + 1'b1;
  endfunction

  // CPU waveform is about to fall: the only safe decision point
  function automatic logic cpu_fall(input logic [PH_W-1:0] p);
    return p[0];
  endfunction

  // PCI waveform is about to fall: end of the half-rate divider cycle
  function automatic logic pci_fall(input logic [PH_W-1:0] p);
    return &p;
  endfunction

  function automatic logic [1:0] lat_step(input logic [1:0] l);
    return (l == LAT_DONE) ? l : l + 2'd1;
  endfunction
endpackage

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] nxt_o,
  output logic            cpu_bnd_o,
  output logic            pci_bnd_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_step(ph_q);
  end

  assign nxt_o     = ph_step(ph_q);
  assign cpu_bnd_o = cpu_fall(ph_q);
  assign pci_bnd_o = pci_fall(ph_q);
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter bit USE_LAT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bnd_i,
  input  logic       stop_i,
  output logic       run_o,
  output logic [1:0] lat_o
);
  logic run_q;
  logic lat_ok;

  generate
    if (USE_LAT) begin : g_lat
      logic [1:0] lat_q;
      always_ff @(posedge clk) begin
        if (rst)         lat_q <= LAT_DONE;
        else if (stop_i) lat_q <= 2'd0;
        else if (bnd_i)  lat_q <= lat_step(lat_q);
      end
      assign lat_o  = lat_q;
      assign lat_ok = (lat_q == LAT_DONE);
    end else begin : g_nolat
      assign lat_o  = LAT_DONE;
      assign lat_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b1;
    else if (bnd_i) begin
      if (stop_i)      run_q <= 1'b0;
      else if (lat_ok) run_q <= 1'b1;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NPCI = 6,
  parameter int NMEM = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic            oe_i,
  input  logic            cpu_stop_n_i,
  input  logic            pci_stop_n_i,
  input  logic            pwr_dn_n_i,
  input  logic [NCPU-1:0] cpu_en_i,
  input  logic [NPCI-1:0] pci_en_i,
  input  logic            pcif_en_i,
  input  logic            ref_en_i,
  input  logic [NMEM-1:0] mem_en_i,
  output logic [NCPU-1:0] cpu_clk_o,
  output logic [NPCI-1:0] pci_clk_o,
  output logic            pcif_clk_o,
  output logic [NCPU-1:0] cpu_oe_o,
  output logic [NPCI-1:0] pci_oe_o,
  output logic            pcif_oe_o,
  output logic            ref_oe_o,
  output logic [NMEM-1:0] mem_oe_o,
  output logic            ref_run_o,
  output logic            mem_run_o
);
  logic [PH_W-1:0] nxt_w;
  logic cpu_bnd_w, pci_bnd_w;
  logic cpu_stop_q, pci_stop_q, pd_q_w;
  logic pd_req_w, cpu_req_w, pci_req_w;
  logic cpu_run_w, pci_run_w, pcif_run_w;
  logic [1:0] lat_w, pci_lat_w, pcif_lat_w;

  clkstop_phase u_phase (
    .clk(clk), .rst(rst), .nxt_o(nxt_w),
    .cpu_bnd_o(cpu_bnd_w), .pci_bnd_o(pci_bnd_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_stop_q <= 1'b1;
      pci_stop_q <= 1'b1;
    end else begin
      cpu_stop_q <= cpu_stop_n_i;
      pci_stop_q <= pci_stop_n_i;
    end
  end

  clkstop_sync #(.STAGES(2)) u_pd_sync (
    .clk(clk), .rst(rst), .d_i(pwr_dn_n_i), .q_o(pd_q_w)
  );

  assign pd_req_w  = ~mode_i & ~pd_q_w;
  assign cpu_req_w = (~mode_i & ~cpu_stop_q) | pd_req_w;
  assign pci_req_w = (~mode_i & ~pci_stop_q) | pd_req_w;

  clkstop_gate #(.USE_LAT(1'b1)) u_cpu_gate (
    .clk(clk), .rst(rst), .bnd_i(cpu_bnd_w), .stop_i(cpu_req_w),
    .run_o(cpu_run_w), .lat_o(lat_w)
  );
  clkstop_gate #(.USE_LAT(1'b0)) u_pci_gate (
    .clk(clk), .rst(rst), .bnd_i(pci_bnd_w), .stop_i(pci_req_w),
    .run_o(pci_run_w), .lat_o(pci_lat_w)
  );
  clkstop_gate #(.USE_LAT(1'b0)) u_pcif_gate (
    .clk(clk), .rst(rst), .bnd_i(pci_bnd_w), .stop_i(pd_req_w),
    .run_o(pcif_run_w), .lat_o(pcif_lat_w)
  );

  // One flop per output; the run flag only changes where the level goes low
  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (rst) cpu_clk_o[i] <= 1'b0;
        else     cpu_clk_o[i] <= nxt_w[0] & cpu_run_w;
      end
    end
    for (genvar j = 0; j < NPCI; j++) begin : g_pci
      always_ff @(posedge clk) begin
        if (rst) pci_clk_o[j] <= 1'b0;
        else     pci_clk_o[j] <= nxt_w[1] & pci_run_w;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pcif_clk_o <= 1'b0;
    else     pcif_clk_o <= nxt_w[1] & pcif_run_w;
  end

  assign cpu_oe_o  = {NCPU{oe_i}} & cpu_en_i;
  assign pci_oe_o  = {NPCI{oe_i}} & pci_en_i;
  assign pcif_oe_o = oe_i & pcif_en_i;
  assign ref_oe_o  = oe_i & ref_en_i;
  assign mem_oe_o  = {NMEM{oe_i}} & mem_en_i;
  assign ref_run_o = ~pd_req_w;
  assign mem_run_o = ~pd_req_w;
endmodule

module clkstop_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_clk,
  input logic       pci_clk,
  input logic       cpu_run,
  input logic       pcif_run,
  input logic       pd_req,
  input logic [1:0] lat,
  input logic       oe,
  input logic       drive_any
);
  assert_cpu_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk) |=> !cpu_clk);
  assert_pci_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_clk) |=> pci_clk);
  assert_cpu_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cpu_run |=> !cpu_clk);
  assert_restart_lat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_run) |-> lat == 2'd3);
  assert_pcif_free_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(pcif_run) |-> $past(pd_req));
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !drive_any);
endmodule

bind clkstop_ctrl clkstop_chk u_chk (
  .clk(clk), .rst(rst), .cpu_clk(cpu_clk_o[0]), .pci_clk(pci_clk_o[0]),
  .cpu_run(cpu_run_w), .pcif_run(pcif_run_w), .pd_req(pd_req_w),
  .lat(lat_w), .oe(oe_i),
  .drive_any(|{cpu_oe_o, pci_oe_o, pcif_oe_o, ref_oe_o, mem_oe_o})
);

// File: tb/clkstop_ctrl_bench.sv
module clkstop_ctrl_bench;
  localparam int NC = 2, NP = 2, NM = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_i = 1'b0, oe_i = 1'b1;
  logic cpu_stop_n_i = 1'b1, pci_stop_n_i = 1'b1, pwr_dn_n_i = 1'b1;
  logic [NC-1:0] cpu_en_i = '1;
  logic [NP-1:0] pci_en_i = '1;
  logic pcif_en_i = 1'b1, ref_en_i = 1'b1;
  logic [NM-1:0] mem_en_i = '1;
  logic [NC-1:0] cpu_clk_o, cpu_oe_o;
  logic [NP-1:0] pci_clk_o, pci_oe_o;
  logic [NM-1:0] mem_oe_o;
  logic pcif_clk_o, pcif_oe_o, ref_oe_o, ref_run_o, mem_run_o;
  int total = 0, bad = 0;
  int wbad_cpu = 0, wbad_pci = 0, wbad_pcif = 0;
  int len_c = 0, len_p = 0, len_f = 0;
  logic pc = 1'b0, pp = 1'b0, pf = 1'b0;

  clkstop_ctrl #(.NCPU(NC), .NPCI(NP), .NMEM(NM)) u_clkstop_ctrl (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6 pulse width monitor: CPU highs last 1 sample, PCI highs 2
  always @(negedge clk) begin
    if (rst) begin
      len_c = 0; len_p = 0; len_f = 0; pc = 0; pp = 0; pf = 0;
    end else begin
      if (cpu_clk_o[0]) len_c++; else begin if (pc && len_c != 1) wbad_cpu++; len_c = 0; end
      if (pci_clk_o[0]) len_p++; else begin if (pp && len_p != 2) wbad_pci++; len_p = 0; end
      if (pcif_clk_o)   len_f++; else begin if (pf && len_f != 2) wbad_pcif++; len_f = 0; end
      pc = cpu_clk_o[0]; pp = pci_clk_o[0]; pf = pcif_clk_o;
    end
  end

  task automatic count_edges(input int n, output int ce, output int pe, output int fe);
    logic c0, p0, f0;
    ce = 0; pe = 0; fe = 0;
    @(negedge clk);
    c0 = cpu_clk_o[0]; p0 = pci_clk_o[0]; f0 = pcif_clk_o;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cpu_clk_o[0] && !c0) ce++;
      if (pci_clk_o[0] && !p0) pe++;
      if (pcif_clk_o && !f0) fe++;
      c0 = cpu_clk_o[0]; p0 = pci_clk_o[0]; f0 = pcif_clk_o;
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ce, pe, fe, n;
    logic [7:0] v;
    wait_clk(3);
    // R1 reset state
    chk(cpu_clk_o == 0 && pci_clk_o == 0 && !pcif_clk_o, "R1 reset low",
        {cpu_clk_o, pci_clk_o, pcif_clk_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_clk_o == '1 && pci_clk_o == 0 && !pcif_clk_o, "R1 first edge",
        {cpu_clk_o, pci_clk_o, pcif_clk_o}, 5'b11000);
    @(negedge clk);
    chk(cpu_clk_o == 0 && pci_clk_o == '1 && pcif_clk_o, "R1 second edge",
        {cpu_clk_o, pci_clk_o, pcif_clk_o}, 5'b00111);
    // R2 rates
    count_edges(40, ce, pe, fe);
    chk(ce == 20, "R2 cpu edges", ce, 20);
    chk(pe == 10, "R2 pci edges", pe, 10);
    chk(fe == 10, "R2 pcif edges", fe, 10);
    // R3 cpu stop
    cpu_stop_n_i = 1'b0;
    wait_clk(6);
    count_edges(16, ce, pe, fe);
    chk(ce == 0 && cpu_clk_o == 0, "R3 cpu held low", ce, 0);
    chk(pe == 4 && fe == 4, "R3 pci keeps running", pe + fe, 8);
    chk(mem_run_o && ref_run_o, "R3 mem runs", mem_run_o, 1);
    // R4 restart latency
    cpu_stop_n_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_clk_o[0] && n < 40);
    chk(n >= 6 && n <= 12, "R4 restart latency", n, 9);
    count_edges(40, ce, pe, fe);
    chk(ce == 20, "R4 cpu resumed", ce, 20);
    // R5 pci stop
    pci_stop_n_i = 1'b0;
    wait_clk(8);
    count_edges(16, ce, pe, fe);
    chk(pe == 0 && pci_clk_o == 0, "R5 pci held low", pe, 0);
    chk(fe == 4, "R5 pcif free", fe, 4);
    chk(ce == 8, "R5 cpu runs", ce, 8);
    pci_stop_n_i = 1'b1;
    wait_clk(8);
    count_edges(40, ce, pe, fe);
    chk(pe == 10, "R5 pci resumed", pe, 10);
    // R7 mode high ignores all controls
    mode_i = 1'b1;
    cpu_stop_n_i = 1'b0; pci_stop_n_i = 1'b0; pwr_dn_n_i = 1'b0;
    wait_clk(8);
    count_edges(40, ce, pe, fe);
    chk(ce == 20 && pe == 10 && fe == 10, "R7 mode high ignored", ce + pe + fe, 40);
    chk(ref_run_o && mem_run_o, "R7 run flags", ref_run_o + mem_run_o, 2);
    // R8 power down
    cpu_stop_n_i = 1'b1; pci_stop_n_i = 1'b1;
    mode_i = 1'b0;
    wait_clk(10);
    count_edges(16, ce, pe, fe);
    chk(ce == 0 && pe == 0 && fe == 0 && cpu_clk_o == 0 && pci_clk_o == 0 && !pcif_clk_o,
        "R8 all low", ce + pe + fe, 0);
    chk(!ref_run_o && !mem_run_o, "R8 run flags low", ref_run_o + mem_run_o, 0);
    chk(cpu_oe_o == '1 && pci_oe_o == '1 && pcif_oe_o && ref_oe_o && mem_oe_o == '1,
        "R8 drive flags kept", {cpu_oe_o, pci_oe_o, pcif_oe_o, ref_oe_o, mem_oe_o}, 8'hFF);
    // R11 release
    pwr_dn_n_i = 1'b1;
    wait_clk(20);
    count_edges(40, ce, pe, fe);
    chk(ce == 20 && pe == 10 && fe == 10, "R11 resumed", ce + pe + fe, 40);
    chk(ref_run_o && mem_run_o, "R11 run flags", ref_run_o + mem_run_o, 2);
    // R6 widths seen over the whole run
    chk(wbad_cpu == 0, "R6 cpu width", wbad_cpu, 0);
    chk(wbad_pci == 0, "R6 pci width", wbad_pci, 0);
    chk(wbad_pcif == 0, "R6 pcif width", wbad_pcif, 0);
    // R9 / R10 sweep: bits [1:0] cpu, [3:2] pci, [4] pcif, [5] ref, [7:6] mem
    for (int o = 0; o < 2; o++) begin
      for (int e = 0; e < 256; e++) begin
        logic [7:0] got, exp;
        @(negedge clk);
        v = 8'(e);
        oe_i = o[0];
        cpu_en_i = v[1:0]; pci_en_i = v[3:2]; pcif_en_i = v[4];
        ref_en_i = v[5]; mem_en_i = v[7:6];
        #1;
        got = {mem_oe_o, ref_oe_o, pcif_oe_o, pci_oe_o, cpu_oe_o};
        exp = (o == 0) ? 8'h00 : v;
        chk(got == exp, (o == 0) ? "R9 oe low" : "R10 enable bits", got, exp);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule